// File: doc/BRIEF.md
# Three-Mode CPU Interrupt Sequencer

This block is the interrupt front end of an 8-bit processor core. It watches a level-sensitive maskable request and an edge-triggered non-maskable request. It holds two interrupt-enable flags and a two-bit mode register. The primary flag gates maskable requests. The shadow flag keeps the primary flag's value across a non-maskable entry, so that the return-from-NMI strobe can restore it.

At each instruction boundary that the decoder marks, the block decides whether to take an interrupt. A non-maskable entry is resolved at once to a fixed service address. A maskable entry first runs an acknowledge fetch cycle that is stretched by wait states. The byte on the data bus at the end of that cycle then becomes one of three things, depending on the mode:
- an opcode handed to the core (mode 0),
- ignored in favour of a fixed address (mode 1),
- the low half of a table pointer whose high half is the I register (mode 2).

Decoder strobes (enable, disable, NMI-return, mode select) count only when they arrive together with the boundary strobe.

Top module: `irq_seq`

## Requirements
- R1: After reset, both enable flags are 0, the mode is 0, and `ack_m1`, `ack_iorq`, `ack_wait` and `svc_valid` are all 0.
- R2: At a boundary, `op_ei` sets both enable flags and `op_di` clears both. Either strobe without `boundary` changes nothing.
- R3: No interrupt of either kind is accepted at a boundary that carries `op_ei` or `op_di`.
- R4: A rising edge on `nmi_req` is latched until accepted. A pending non-maskable request beats a maskable one at the same boundary. Acceptance gives, one cycle after the boundary, `svc_valid`=1, `svc_nmi`=1 and `svc_addr`=16'h0066. It clears `iff1_o` and leaves `iff2_o` unchanged. A level held high does not re-trigger.
- R5: `op_retn` at a boundary copies `iff2_o` into `iff1_o`.
- R6: A maskable request is accepted only when `int_req`=1 and `iff1_o`=1 at the boundary. Acceptance clears both enable flags.
- R7: The maskable acknowledge lasts WAIT_STATES+2 cycles, starting the cycle after the boundary. `ack_m1` is high throughout. `ack_iorq` is high in all cycles except the first. `ack_wait` is high in cycles 2 to WAIT_STATES+1. `data_in` is sampled in the last cycle, and `svc_valid` (with `svc_nmi`=0) follows in the next cycle.
- R8: In mode 1, `svc_addr` is 16'h0038.
- R9: In mode 2, `svc_addr` is {`i_reg`, `data_in`[7:1], 1'b0}.
- R10: In mode 0, `svc_is_op`=1, `svc_opcode` equals the sampled byte, and `svc_addr` is 0.
- R11: While `bus_req`=1, no interrupt is accepted. A latched non-maskable edge stays pending and is taken at the first boundary after `bus_req` falls.
- R12: `op_im` at a boundary loads the mode from `im_sel` when `im_sel` is 0, 1 or 2. The value 3 leaves the mode unchanged. The mode is visible on `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| op_ei | input | 1 | Enable-interrupts strobe |
| op_di | input | 1 | Disable-interrupts strobe |
| op_retn | input | 1 | Return-from-NMI strobe |
| op_im | input | 1 | Mode-select strobe |
| im_sel | input | 2 | Mode requested by `op_im` |
| int_req | input | 1 | Maskable request, level, active high |
| nmi_req | input | 1 | Non-maskable request, rising edge |
| bus_req | input | 1 | External bus request active |
| i_reg | input | 8 | Table page register |
| data_in | input | 8 | Data bus input |
| ack_m1 | output | 1 | Acknowledge fetch cycle in progress |
| ack_iorq | output | 1 | I/O request strobe of the acknowledge |
| ack_wait | output | 1 | Automatic wait state |
| busy | output | 1 | Acknowledge in progress |
| svc_valid | output | 1 | Service result valid for one cycle |
| svc_nmi | output | 1 | Result comes from a non-maskable entry |
| svc_is_op | output | 1 | Result is an opcode (mode 0) |
| svc_addr | output | 16 | Service address |
| svc_opcode | output | 8 | Opcode for mode 0 |
| iff1_o | output | 1 | Primary enable flag |
| iff2_o | output | 1 | Shadow enable flag, parity/overflow status |
| mode_o | output | 2 | Current interrupt mode |

## Verification
The assertions assume that decoder strobes arrive only together with `boundary`. They also assume that `boundary` is never raised while `busy` is high, since the core is stalled during an acknowledge. The stimulus pulses every strobe with `boundary` in the same single cycle. It waits for each acknowledge to complete before the next boundary. Only the enable-without-boundary case breaks the first assumption, and no property depends on it.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int WAIT_STATES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary,
  input  logic        op_ei,
  input  logic        op_di,
  input  logic        op_retn,
  input  logic        op_im,
  input  logic [1:0]  im_sel,
  input  logic        int_req,
  input  logic        nmi_req,
  input  logic        bus_req,
  input  logic [7:0]  i_reg,
  input  logic [7:0]  data_in,
  output logic        ack_m1,
  output logic        ack_iorq,
  output logic        ack_wait,
  output logic        busy,
  output logic        svc_valid,
  output logic        svc_nmi,
  output logic        svc_is_op,
  output logic [15:0] svc_addr,
  output logic [7:0]  svc_opcode,
  output logic        iff1_o,
  output logic        iff2_o,
  output logic [1:0]  mode_o
);
  localparam int CW = $clog2(WAIT_STATES + 2);
  localparam logic [CW-1:0] LAST = CW'(WAIT_STATES + 1);
  localparam logic [15:0] NMI_ADDR = 16'h0066;
  localparam logic [15:0] FIX_ADDR = 16'h0038;

  logic iff1, iff2, nmi_d, nmi_pend, in_ack;
  logic [1:0] mode;
  logic [CW-1:0] cnt;

  wire strobe_ok = boundary && !in_ack;
  wire sample_ok = strobe_ok && !bus_req && !op_ei && !op_di;
  wire take_nmi  = sample_ok && nmi_pend;
  wire take_int  = sample_ok && !nmi_pend && int_req && iff1;
  wire ack_end   = in_ack && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1       <= 1'b0;
      iff2       <= 1'b0;
      mode       <= 2'd0;
      nmi_d      <= 1'b0;
      nmi_pend   <= 1'b0;
      in_ack     <= 1'b0;
      cnt        <= '0;
      svc_valid  <= 1'b0;
      svc_nmi    <= 1'b0;
      svc_is_op  <= 1'b0;
      svc_addr   <= '0;
      svc_opcode <= '0;
    end else begin
      nmi_d     <= nmi_req;
      nmi_pend  <= (nmi_pend && !take_nmi) || (nmi_req && !nmi_d);
      svc_valid <= 1'b0;
      if (strobe_ok) begin
        if (op_di) begin
          iff1 <= 1'b0;
          iff2 <= 1'b0;
        end else if (op_ei) begin
          iff1 <= 1'b1;
          iff2 <= 1'b1;
        end else if (op_retn) begin
          iff1 <= iff2;
        end
        if (op_im && im_sel != 2'd3) mode <= im_sel;
      end
      if (take_nmi) begin
        iff1      <= 1'b0;
        svc_valid <= 1'b1;
        svc_nmi   <= 1'b1;
        svc_is_op <= 1'b0;
        svc_addr  <= NMI_ADDR;
      end
      if (take_int) begin
        iff1   <= 1'b0;
        iff2   <= 1'b0;
        in_ack <= 1'b1;
        cnt    <= '0;
      end
      if (in_ack) begin
        cnt <= cnt + 1'b1;
        if (ack_end) begin
          in_ack    <= 1'b0;
          svc_valid <= 1'b1;
          svc_nmi   <= 1'b0;
          svc_is_op <= (mode == 2'd0);
          svc_opcode <= data_in;
          case (mode)
            2'd1:    svc_addr <= FIX_ADDR;
            2'd2:    svc_addr <= {i_reg, data_in[7:1], 1'b0};
            default: svc_addr <= '0;
          endcase
        end
      end
    end
  end

  assign ack_m1   = in_ack;
  assign ack_iorq = in_ack && (cnt != '0);
  assign ack_wait = ack_iorq && !ack_end;
  assign busy     = in_ack;
  assign iff1_o   = iff1;
  assign iff2_o   = iff2;
  assign mode_o   = mode;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        op_ei,
  input logic        op_di,
  input logic        bus_req,
  input logic        ack_m1,
  input logic        ack_iorq,
  input logic        ack_wait,
  input logic        svc_valid,
  input logic        svc_nmi,
  input logic [15:0] svc_addr,
  input logic        iff1_o,
  input logic        iff2_o,
  input logic        busy
);
  p_ei_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !busy && op_ei && !op_di |=> iff1_o && iff2_o);
  p_di_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !busy && op_di |=> !iff1_o && !iff2_o);
  p_no_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && (op_ei || op_di) |=> !svc_valid && !$rose(ack_m1));
  p_nmi_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && svc_nmi |-> svc_addr == 16'h0066 && !iff1_o);
  p_int_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_m1) |-> $past(iff1_o) && !iff1_o && !iff2_o);
  p_first_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_m1) |-> !ack_iorq);
  p_wait_in_iorq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wait |-> ack_iorq && ack_m1);
  p_result_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && !svc_nmi |-> $past(ack_iorq) && !ack_m1);
  p_even_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> !svc_addr[0]);
  p_busreq_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_m1) |-> $past(!bus_req));
endmodule

bind irq_seq irq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .op_ei(op_ei), .op_di(op_di),
  .bus_req(bus_req), .ack_m1(ack_m1), .ack_iorq(ack_iorq), .ack_wait(ack_wait),
  .svc_valid(svc_valid), .svc_nmi(svc_nmi), .svc_addr(svc_addr),
  .iff1_o(iff1_o), .iff2_o(iff2_o), .busy(busy)
);

// File: tb/irq_seq_tb.sv
`timescale 1ns/1ps
module irq_seq_tb;
  logic clk = 0, rst_n = 0;
  logic boundary = 0, op_ei = 0, op_di = 0, op_retn = 0, op_im = 0;
  logic [1:0] im_sel = 0;
  logic int_req = 0, nmi_req = 0, bus_req = 0;
  logic [7:0] i_reg = 0, data_in = 0;
  logic ack_m1, ack_iorq, ack_wait, busy, svc_valid, svc_nmi, svc_is_op;
  logic [15:0] svc_addr;
  logic [7:0] svc_opcode;
  logic iff1_o, iff2_o;
  logic [1:0] mode_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_seq u_dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bnd(bit ei = 0, bit di = 0, bit retn = 0, bit im = 0, logic [1:0] sel = 0);
    @(negedge clk);
    boundary = 1; op_ei = ei; op_di = di; op_retn = retn; op_im = im; im_sel = sel;
    @(negedge clk);
    boundary = 0; op_ei = 0; op_di = 0; op_retn = 0; op_im = 0;
  endtask

  task automatic run_ack(logic [7:0] byte_in);
    chk("R7 t1 m1", 16'(ack_m1), 16'd1);
    chk("R7 t1 iorq", 16'(ack_iorq), 16'd0);
    @(negedge clk);
    chk("R7 w1", {ack_m1, ack_iorq, ack_wait}, 16'b111);
    @(negedge clk);
    chk("R7 w2", {ack_m1, ack_iorq, ack_wait}, 16'b111);
    data_in = byte_in;
    @(negedge clk);
    chk("R7 t3", {ack_m1, ack_iorq, ack_wait}, 16'b110);
    @(negedge clk);
    data_in = 8'h00;
    chk("R7 done", {ack_m1, svc_valid, svc_nmi}, 16'b010);
  endtask

  task automatic t_reset();
    chk("R1 flags", {iff1_o, iff2_o}, 16'd0);
    chk("R1 mode", 16'(mode_o), 16'd0);
    chk("R1 outs", {ack_m1, ack_iorq, ack_wait, svc_valid}, 16'd0);
  endtask

  task automatic t_enable();
    bnd(.ei(1));
    chk("R2 ei", {iff1_o, iff2_o}, 16'b11);
    bnd(.di(1));
    chk("R2 di", {iff1_o, iff2_o}, 16'b00);
    @(negedge clk); op_ei = 1;
    @(negedge clk); op_ei = 0;
    chk("R2 ei no boundary", {iff1_o, iff2_o}, 16'b00);
  endtask

  task automatic t_no_sample();
    bnd(.ei(1));
    int_req = 1;
    bnd(.ei(1));
    chk("R3 ei boundary", {ack_m1, svc_valid}, 16'b00);
    bnd(.di(1));
    chk("R3 di boundary", {ack_m1, svc_valid, iff1_o}, 16'b000);
    int_req = 0;
  endtask

  task automatic t_mode1();
    bnd(.im(1), .sel(2'd1));
    chk("R12 mode1", 16'(mode_o), 16'd1);
    bnd(.ei(1));
    int_req = 1;
    bnd();
    run_ack(8'hAB);
    int_req = 0;
    chk("R8 addr", svc_addr, 16'h0038);
    chk("R6 flags cleared", {iff1_o, iff2_o}, 16'b00);
    int_req = 1;
    bnd();
    chk("R6 masked", {ack_m1, svc_valid}, 16'b00);
    int_req = 0;
  endtask

  task automatic t_mode2();
    bnd(.im(1), .sel(2'd2));
    bnd(.ei(1));
    i_reg = 8'h12; int_req = 1;
    bnd();
    run_ack(8'h35);
    int_req = 0;
    chk("R9 addr", svc_addr, 16'h1234);
    chk("R9 not op", 16'(svc_is_op), 16'd0);
    bnd(.im(1), .sel(2'd3));
    chk("R12 sel3 ignored", 16'(mode_o), 16'd2);
  endtask

  task automatic t_mode0();
    bnd(.im(1), .sel(2'd0));
    bnd(.ei(1));
    int_req = 1;
    bnd();
    run_ack(8'hFF);
    int_req = 0;
    chk("R10 op flag", 16'(svc_is_op), 16'd1);
    chk("R10 opcode", 16'(svc_opcode), 16'h00FF);
    chk("R10 addr", svc_addr, 16'h0000);
  endtask

  task automatic t_nmi();
    bnd(.ei(1));
    int_req = 1;
    @(negedge clk); nmi_req = 1;
    bnd();
    chk("R4 svc", {svc_valid, svc_nmi, ack_m1}, 16'b110);
    chk("R4 addr", svc_addr, 16'h0066);
    chk("R4 flags", {iff1_o, iff2_o}, 16'b01);
    int_req = 0;
    bnd();
    chk("R4 level no retrigger", 16'(svc_valid), 16'd0);
    bnd(.retn(1));
    chk("R5 retn", {iff1_o, iff2_o}, 16'b11);
    nmi_req = 0;
  endtask

  task automatic t_busreq();
    bnd(.ei(1));
    @(negedge clk); nmi_req = 1; bus_req = 1;
    @(negedge clk); nmi_req = 0;
    bnd();
    chk("R11 nmi blocked", 16'(svc_valid), 16'd0);
    bus_req = 0;
    bnd();
    chk("R11 nmi later", {svc_valid, svc_nmi}, 16'b11);
    bnd(.retn(1));
    bus_req = 1; int_req = 1;
    bnd();
    chk("R11 int blocked", {ack_m1, svc_valid}, 16'b00);
    bus_req = 0; int_req = 0;
    bnd(.di(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_no_sample();
    t_mode1();
    t_mode2();
    t_mode0();
    t_nmi();
    t_busreq();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule